// File: doc/BRIEF.md
# CAN Fault-Confinement Tracker with Bus-Off Recovery

This block follows the fault-confinement state of one CAN node. The bit engine reports each error-counter update as a single-cycle input: an amount to add to the transmit or receive error count, or a decrement of one after a successful frame. The block keeps both counts and derives the node state from them: error-active, error-warning, error-passive or bus-off. It presents the counts and the state flags in a 32-bit status word. Each time the state changes to warning, to passive or back to active, it emits a one-cycle event that carries the status word.

When the transmit count would exceed 255, the node goes bus-off. In that cycle the block marks every pending transmit slot for abort. It leaves bus-off only after a grace period. While the host holds reset mode, nothing is counted. Once reset mode is released, the block counts idle conditions on the bus. An idle condition is a run of consecutive recessive bits. When enough idle conditions have been seen, the counters clear, the node is error-active again, and a drain strobe tells the transmit queue to flush the frames it had already aborted.

A separate path formats bus-error capture information from the bit engine into an 8-bit code. The code packs the bit position within the frame, the direction and the error type.

Top module: `can_fault_conf`

## Requirements
- R1: `status_word` bits 7:0 hold the receive error count and bits 15:8 hold the transmit error count. Bit 17 is warning, bit 18 is passive and bit 19 is bus-off. Bit 16 and bits 31:20 are always zero.
- R2: Bus-off is flagged when the node is bus-off. Otherwise passive is flagged when either count is 128 or more. Otherwise warning is flagged when either count is 96 or more. At most one of the three flags is set at any time.
- R3: The edge that samples the inputs adds `tx_err_add` to the transmit count and `rx_err_add` to the receive count. A decrement input lowers its count by one and never below zero. An add in the same cycle wins over a decrement. The receive count saturates at 255.
- R4: An add that would take the transmit count above 255 holds the count at 255 and makes the node bus-off. While the node is bus-off, all four counter inputs are ignored.
- R5: In the first cycle in which the bus-off flag is set, `abort_mask` equals `tx_pending`. In every other cycle `abort_mask` is zero.
- R6: While bus-off with `host_reset_mode` low, each `bit_tick` with `bus_rx` high (recessive) extends the current recessive run. A tick with `bus_rx` low (dominant) restarts the run. Every 11 recessive ticks form one idle condition. The grace period ends exactly on the tick that completes the 128th idle condition.
- R7: When the grace period ends, both counts read zero and the state is error-active. `tx_drain` is high for exactly that one cycle.
- R8: `state_evt` is high for one cycle whenever the state becomes warning, passive or active from a different state, with `evt_status` equal to `status_word`. It stays low on entry to bus-off.
- R9: While `host_reset_mode` is high, no idle conditions are counted, and any partial count restarts from zero.
- R10: One cycle after `cap_valid`, `cap_strobe` is high and `cap_code` holds `cap_seg` in bits 4:0 and `cap_rx` in bit 5 (1 means the error occurred while receiving). Bits 7:6 hold the type: 00 for a bit error, 01 for a form error, 10 for a stuff error and 11 for anything else. The type comes from the one-hot `cap_kind` (bit 0 bit, bit 1 form, bit 2 stuff); a `cap_kind` with no bit or several bits set counts as other. Without `cap_valid`, `cap_code` holds its value.
- R11: After reset, both counts are zero, the state is error-active, and `status_word`, `abort_mask`, `tx_drain`, `state_evt`, `cap_strobe` and `cap_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_add | input | ADD_W | Amount added to the transmit error count |
| tx_ok_dec | input | 1 | Decrement the transmit error count by one |
| rx_err_add | input | ADD_W | Amount added to the receive error count |
| rx_ok_dec | input | 1 | Decrement the receive error count by one |
| tx_pending | input | SLOTS | Transmit slots currently holding frames |
| host_reset_mode | input | 1 | Host holds the controller in reset mode |
| bit_tick | input | 1 | One strobe per nominal bit time |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| cap_valid | input | 1 | Bus-error capture strobe |
| cap_seg | input | 5 | Bit position in the frame where the error occurred |
| cap_rx | input | 1 | Error occurred while receiving |
| cap_kind | input | 3 | One-hot error kind: bit, form, stuff |
| status_word | output | 32 | Counts and state flags |
| state_evt | output | 1 | State-change event |
| evt_status | output | 32 | Status word carried with the event |
| abort_mask | output | SLOTS | Slots to abort on entry to bus-off |
| tx_drain | output | 1 | Grace period over; flush the aborted frames |
| cap_code | output | 8 | Formatted error capture code |
| cap_strobe | output | 1 | `cap_code` updated |

## Verification
The counter path is driven by a sequence of single and repeated add and decrement patterns. The sequence separates an add from a decrement in the same cycle, shows that the decrement stops at zero and the receive count saturates, and crosses each threshold from both directions, so that off-by-one thresholds and events that should not fire can be told apart. Bus-off is entered with an add that overshoots 255 and a distinctive pending mask. The bench then applies counter inputs to confirm that they are frozen. Recovery is tried with a long stretch held in reset mode, a dominant bit that breaks a run partway through, and an exact count of 1407 versus 1408 recessive ticks, which exposes gating mistakes and off-by-one errors in either counter. The capture formatter gets every type encoding, both directions, the extreme segment values, an empty and a multi-bit kind, and a hold cycle.

// File: rtl/can_fc_pkg.sv
// Package: shared state type, status-word bit positions and capture type codes
// for the CAN fault-confinement tracker.
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARN    = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    localparam int ST_WARN_BIT = 17;
    localparam int ST_PASS_BIT = 18;
    localparam int ST_BOFF_BIT = 19;

    localparam logic [1:0] CAP_T_BIT   = 2'b00;
    localparam logic [1:0] CAP_T_FORM  = 2'b01;
    localparam logic [1:0] CAP_T_STUFF = 2'b10;
    localparam logic [1:0] CAP_T_OTHER = 2'b11;

endpackage

// File: rtl/can_err_counters.sv
// Module: can_err_counters
// Holds the transmit and receive error counts and the sticky bus-off flag.
// Assumes: ADD_W <= 8. An add wins over a decrement in the same cycle.
// The counts freeze while bus-off, and `recover` clears everything.
module can_err_counters #(
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] tx_add,
    input  logic             tx_dec,
    input  logic [ADD_W-1:0] rx_add,
    input  logic             rx_dec,
    input  logic             recover,
    output logic [7:0]       tec,
    output logic [7:0]       rec,
    output logic             bus_off
);
    localparam int PADW = 9 - ADD_W;

    logic [8:0] tx_sum;
    logic [8:0] rx_sum;

    // Widened sums so that an overflow past 255 can be detected.
    always_comb begin
        tx_sum = {1'b0, tec} + {{PADW{1'b0}}, tx_add};
        rx_sum = {1'b0, rec} + {{PADW{1'b0}}, rx_add};
    end

    // Transmit count and bus-off entry.
    always_ff @(posedge clk) begin
        if (!rst_n || recover) begin
            tec     <= '0;
            bus_off <= 1'b0;
        end else if (!bus_off) begin
            if (tx_add != '0) begin
                if (tx_sum[8]) begin
                    tec     <= 8'hFF;
                    bus_off <= 1'b1;
                end else begin
                    tec <= tx_sum[7:0];
                end
            end else if (tx_dec && tec != 8'd0) begin
                tec <= tec - 8'd1;
            end
        end
    end

    // Receive count, saturating at 255.
    always_ff @(posedge clk) begin
        if (!rst_n || recover) begin
            rec <= '0;
        end else if (!bus_off) begin
            if (rx_add != '0) begin
                rec <= rx_sum[8] ? 8'hFF : rx_sum[7:0];
            end else if (rx_dec && rec != 8'd0) begin
                rec <= rec - 8'd1;
            end
        end
    end

    // R4
    busoff_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> tec == 8'hFF);

    // R4
    busoff_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && $past(bus_off)) |-> ($stable(tec) && $stable(rec)));

endmodule

// File: rtl/can_busoff_recovery.sv
// Module: can_busoff_recovery
// Counts idle conditions (IDLE_BITS consecutive recessive bits) while the node
// is bus-off and the host has released reset mode.
// Assumes: bit_tick is a single-cycle strobe per bit and bus_rx is valid with it.
module can_busoff_recovery #(
    parameter int IDLE_BITS  = 11,
    parameter int IDLE_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_off,
    input  logic reset_mode,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic grace_done
);
    localparam int RUN_W = $clog2(IDLE_BITS + 1);
    localparam int IDL_W = $clog2(IDLE_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_BITS - 1);
    localparam logic [IDL_W-1:0] IDL_LAST = IDL_W'(IDLE_COUNT - 1);

    logic [RUN_W-1:0] run_cnt;
    logic [IDL_W-1:0] idle_cnt;
    logic             armed;
    logic             run_full;

    // Counting is allowed only in bus-off with reset mode released.
    always_comb begin
        armed      = bus_off && !reset_mode;
        run_full   = bit_tick && bus_rx && (run_cnt == RUN_LAST);
        grace_done = armed && run_full && (idle_cnt == IDL_LAST);
    end

    // Recessive-run and idle-condition counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            run_cnt  <= '0;
            idle_cnt <= '0;
        end else if (bit_tick) begin
            if (!bus_rx) begin
                run_cnt <= '0;
            end else if (run_full) begin
                run_cnt  <= '0;
                idle_cnt <= grace_done ? '0 : idle_cnt + 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R6
    idle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt <= IDL_LAST) && (run_cnt <= RUN_LAST));

    // R9
    hold_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reset_mode) |-> (idle_cnt == '0 && run_cnt == '0));

endmodule

// File: rtl/can_cap_format.sv
// Module: can_cap_format
// Packs a bus-error capture into an 8-bit code: bits 7:6 type, bit 5 direction
// (1 = receiving), bits 4:0 position in the frame. Registered; holds when idle.
// Assumes: cap_kind is one-hot {stuff, form, bit}; any other value means "other".
module can_cap_format
    import can_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_valid,
    input  logic [4:0] cap_seg,
    input  logic       cap_rx,
    input  logic [2:0] cap_kind,
    output logic [7:0] cap_code,
    output logic       cap_strobe
);
    logic [1:0] kind_code;

    // Map the one-hot kind to the two-bit type field.
    always_comb begin
        case (cap_kind)
            3'b001:  kind_code = CAP_T_BIT;
            3'b010:  kind_code = CAP_T_FORM;
            3'b100:  kind_code = CAP_T_STUFF;
            default: kind_code = CAP_T_OTHER;
        endcase
    end

    // Capture register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_code   <= '0;
            cap_strobe <= 1'b0;
        end else begin
            cap_strobe <= cap_valid;
            if (cap_valid) begin
                cap_code <= {kind_code, cap_rx, cap_seg};
            end
        end
    end

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |-> $stable(cap_code) || $past(!rst_n));

    // R10
    cap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> (cap_code[5] == $past(cap_rx)));

endmodule

// File: rtl/can_fault_conf.sv
// Module: can_fault_conf (top)
// Derives the fault-confinement state from the error counts and builds the
// status word. Raises state-change events, aborts pending slots on bus-off
// entry and signals the queue drain when recovery completes.
// Assumes: the counter update rules are applied upstream by the bit engine.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int ADD_W         = 4,
    parameter int SLOTS         = 16,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 128,
    parameter int IDLE_BITS     = 11,
    parameter int IDLE_COUNT    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] tx_err_add,
    input  logic             tx_ok_dec,
    input  logic [ADD_W-1:0] rx_err_add,
    input  logic             rx_ok_dec,
    input  logic [SLOTS-1:0] tx_pending,
    input  logic             host_reset_mode,
    input  logic             bit_tick,
    input  logic             bus_rx,
    input  logic             cap_valid,
    input  logic [4:0]       cap_seg,
    input  logic             cap_rx,
    input  logic [2:0]       cap_kind,
    output logic [31:0]      status_word,
    output logic             state_evt,
    output logic [31:0]      evt_status,
    output logic [SLOTS-1:0] abort_mask,
    output logic             tx_drain,
    output logic [7:0]       cap_code,
    output logic             cap_strobe
);
    localparam logic [7:0] WARN_TH = 8'(WARN_LIMIT);
    localparam logic [7:0] PASS_TH = 8'(PASSIVE_LIMIT);

    logic [7:0] tec;
    logic [7:0] rec;
    logic       bus_off;
    logic       grace_done;
    fc_state_e  state;
    fc_state_e  prev_state;

    can_err_counters #(.ADD_W(ADD_W)) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_add  (tx_err_add),
        .tx_dec  (tx_ok_dec),
        .rx_add  (rx_err_add),
        .rx_dec  (rx_ok_dec),
        .recover (grace_done),
        .tec     (tec),
        .rec     (rec),
        .bus_off (bus_off)
    );

    can_busoff_recovery #(.IDLE_BITS(IDLE_BITS), .IDLE_COUNT(IDLE_COUNT)) u_recovery (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_off    (bus_off),
        .reset_mode (host_reset_mode),
        .bit_tick   (bit_tick),
        .bus_rx     (bus_rx),
        .grace_done (grace_done)
    );

    can_cap_format u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_valid  (cap_valid),
        .cap_seg    (cap_seg),
        .cap_rx     (cap_rx),
        .cap_kind   (cap_kind),
        .cap_code   (cap_code),
        .cap_strobe (cap_strobe)
    );

    // State from the counts, with bus-off taking priority over passive and warning.
    always_comb begin
        if (bus_off)
            state = FC_BUSOFF;
        else if (tec >= PASS_TH || rec >= PASS_TH)
            state = FC_PASSIVE;
        else if (tec >= WARN_TH || rec >= WARN_TH)
            state = FC_WARN;
        else
            state = FC_ACTIVE;
    end

    // Remember the previous state to detect transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_state <= FC_ACTIVE;
        else        prev_state <= state;
    end

    // Delay the end of the grace period to line up with the cleared counters.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_drain <= 1'b0;
        else        tx_drain <= grace_done;
    end

    // Status word, events and the abort mask.
    always_comb begin
        status_word = '0;
        status_word[7:0]         = rec;
        status_word[15:8]        = tec;
        status_word[ST_WARN_BIT] = (state == FC_WARN);
        status_word[ST_PASS_BIT] = (state == FC_PASSIVE);
        status_word[ST_BOFF_BIT] = (state == FC_BUSOFF);
        state_evt  = (state != prev_state) && (state != FC_BUSOFF);
        evt_status = status_word;
        abort_mask = (state == FC_BUSOFF && prev_state != FC_BUSOFF) ? tx_pending : '0;
    end

    // R2
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_word[ST_BOFF_BIT:ST_WARN_BIT]));

    // R5
    abort_only_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_mask != '0) |-> bus_off);

    // R7
    drain_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drain |-> (tec == 8'd0 && rec == 8'd0 && !bus_off));

    // R8
    evt_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drain |-> state_evt);

endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tx_err_add = '0;
    logic        tx_ok_dec = 1'b0;
    logic [3:0]  rx_err_add = '0;
    logic        rx_ok_dec = 1'b0;
    logic [15:0] tx_pending = '0;
    logic        host_reset_mode = 1'b0;
    logic        bit_tick = 1'b0;
    logic        bus_rx = 1'b1;
    logic        cap_valid = 1'b0;
    logic [4:0]  cap_seg = '0;
    logic        cap_rx = 1'b0;
    logic [2:0]  cap_kind = '0;
    logic [31:0] status_word;
    logic        state_evt;
    logic [31:0] evt_status;
    logic [15:0] abort_mask;
    logic        tx_drain;
    logic [7:0]  cap_code;
    logic        cap_strobe;

    int checks = 0;
    int fails  = 0;

    can_fault_conf uut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_add(tx_err_add), .tx_ok_dec(tx_ok_dec),
        .rx_err_add(rx_err_add), .rx_ok_dec(rx_ok_dec),
        .tx_pending(tx_pending), .host_reset_mode(host_reset_mode),
        .bit_tick(bit_tick), .bus_rx(bus_rx),
        .cap_valid(cap_valid), .cap_seg(cap_seg), .cap_rx(cap_rx), .cap_kind(cap_kind),
        .status_word(status_word), .state_evt(state_evt), .evt_status(evt_status),
        .abort_mask(abort_mask), .tx_drain(tx_drain),
        .cap_code(cap_code), .cap_strobe(cap_strobe)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [7:0] rep;
        logic [3:0] txa;
        logic       txd;
        logic [3:0] rxa;
        logic       rxd;
        logic [7:0] etec;
        logic [7:0] erec;
        logic [2:0] eflags;
        logic       eevt;
    } vec_t;

    // Cumulative counter walk; eflags = {busoff, passive, warning}.
    localparam vec_t VECS [13] = '{
        '{8'd1,  4'd8,  1'b0, 4'd0,  1'b0, 8'd8,   8'd0,   3'b000, 1'b0},
        '{8'd1,  4'd0,  1'b0, 4'd15, 1'b0, 8'd8,   8'd15,  3'b000, 1'b0},
        '{8'd1,  4'd0,  1'b1, 4'd0,  1'b0, 8'd7,   8'd15,  3'b000, 1'b0},
        '{8'd1,  4'd8,  1'b1, 4'd0,  1'b0, 8'd15,  8'd15,  3'b000, 1'b0},
        '{8'd10, 4'd8,  1'b0, 4'd0,  1'b0, 8'd95,  8'd15,  3'b000, 1'b0},
        '{8'd1,  4'd1,  1'b0, 4'd0,  1'b0, 8'd96,  8'd15,  3'b001, 1'b1},
        '{8'd1,  4'd0,  1'b1, 4'd0,  1'b0, 8'd95,  8'd15,  3'b000, 1'b1},
        '{8'd3,  4'd15, 1'b0, 4'd0,  1'b0, 8'd140, 8'd15,  3'b010, 1'b1},
        '{8'd20, 4'd0,  1'b0, 4'd0,  1'b1, 8'd140, 8'd0,   3'b010, 1'b0},
        '{8'd20, 4'd0,  1'b0, 4'd15, 1'b0, 8'd140, 8'd255, 3'b010, 1'b0},
        '{8'd5,  4'd0,  1'b0, 4'd0,  1'b1, 8'd140, 8'd250, 3'b010, 1'b0},
        '{8'd13, 4'd0,  1'b1, 4'd0,  1'b0, 8'd127, 8'd250, 3'b010, 1'b0},
        '{8'd8,  4'd15, 1'b0, 4'd0,  1'b0, 8'd247, 8'd250, 3'b010, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic zero_counter_inputs();
        tx_err_add = '0; tx_ok_dec = 1'b0; rx_err_add = '0; rx_ok_dec = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int drains;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 status", status_word, 32'h0);
        chk("R11 abort", {16'h0, abort_mask}, 32'h0);
        chk("R11 drain/evt/strobe", {29'h0, tx_drain, state_evt, cap_strobe}, 32'h0);
        chk("R11 cap_code", {24'h0, cap_code}, 32'h0);

        // R3 R2 R8 R1: counter walk
        for (int i = 0; i < 13; i++) begin
            for (int r = 0; r < int'(VECS[i].rep); r++) begin
                tx_err_add = VECS[i].txa; tx_ok_dec = VECS[i].txd;
                rx_err_add = VECS[i].rxa; rx_ok_dec = VECS[i].rxd;
                step();
            end
            zero_counter_inputs();
            chk($sformatf("R3 tec step %0d", i), {24'h0, status_word[15:8]}, {24'h0, VECS[i].etec});
            chk($sformatf("R3 rec step %0d", i), {24'h0, status_word[7:0]}, {24'h0, VECS[i].erec});
            chk($sformatf("R2 flags step %0d", i), {29'h0, status_word[19:17]}, {29'h0, VECS[i].eflags});
            chk($sformatf("R8 evt step %0d", i), {31'h0, state_evt}, {31'h0, VECS[i].eevt});
            if (VECS[i].eevt)
                chk($sformatf("R8 evt_status step %0d", i), evt_status, status_word);
            chk($sformatf("R1 zero bits step %0d", i), {19'h0, status_word[31:20], status_word[16]}, 32'h0);
        end

        // R4 R5: bus-off entry with a pending mask; reset mode held by host
        host_reset_mode = 1'b1;
        tx_pending = 16'hA5C3;
        tx_err_add = 4'd15;
        step();
        zero_counter_inputs();
        chk("R4 busoff flags", {29'h0, status_word[19:17]}, 32'h4);
        chk("R4 tec held", {24'h0, status_word[15:8]}, 32'hFF);
        chk("R5 abort on entry", {16'h0, abort_mask}, 32'hA5C3);
        chk("R8 no evt on busoff", {31'h0, state_evt}, 32'h0);
        tx_ok_dec = 1'b1; rx_err_add = 4'd5;
        step();
        zero_counter_inputs();
        chk("R5 abort one cycle", {16'h0, abort_mask}, 32'h0);
        chk("R4 inputs ignored", {16'h0, status_word[15:0]}, {16'h0, 8'hFF, 8'd250});

        // R9: idle bus while reset mode is held counts nothing
        drains = 0;
        bit_tick = 1'b1; bus_rx = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            step();
            if (tx_drain) drains++;
        end
        chk("R9 still busoff in reset mode", {31'h0, status_word[19]}, 32'h1);
        chk("R9 no drain in reset mode", drains, 0);

        // R6: release, a dominant bit breaks a run, then the exact tick count
        host_reset_mode = 1'b0;
        repeat (10) step();
        bus_rx = 1'b0;
        step();
        bus_rx = 1'b1;
        for (int k = 0; k < 1407; k++) begin
            step();
            if (tx_drain) drains++;
        end
        chk("R6 busoff after 1407 ticks", {31'h0, status_word[19]}, 32'h1);
        chk("R6 no early drain", drains, 0);
        step();
        chk("R7 counts cleared and active", status_word, 32'h0);
        chk("R7 drain pulse", {31'h0, tx_drain}, 32'h1);
        chk("R8 evt on return to active", {31'h0, state_evt}, 32'h1);
        chk("R8 evt_status", evt_status, 32'h0);
        bit_tick = 1'b0;
        step();
        chk("R7 drain single cycle", {31'h0, tx_drain}, 32'h0);
        chk("R8 evt single cycle", {31'h0, state_evt}, 32'h0);

        // R10: capture code formatting
        cap_valid = 1'b1; cap_seg = 5'h1A; cap_rx = 1'b1; cap_kind = 3'b001;
        step();
        chk("R10 bit rx", {23'h0, cap_strobe, cap_code}, {23'h0, 1'b1, 8'h3A});
        cap_seg = 5'h03; cap_rx = 1'b0; cap_kind = 3'b010;
        step();
        chk("R10 form tx", {24'h0, cap_code}, 32'h43);
        cap_seg = 5'h1F; cap_rx = 1'b1; cap_kind = 3'b100;
        step();
        chk("R10 stuff rx", {24'h0, cap_code}, 32'hBF);
        cap_seg = 5'h00; cap_rx = 1'b0; cap_kind = 3'b011;
        step();
        chk("R10 multi kind other", {24'h0, cap_code}, 32'hC0);
        cap_seg = 5'h08; cap_rx = 1'b1; cap_kind = 3'b000;
        step();
        chk("R10 empty kind other", {24'h0, cap_code}, 32'hE8);
        cap_valid = 1'b0; cap_seg = 5'h11; cap_kind = 3'b001;
        step();
        chk("R10 hold without valid", {23'h0, cap_strobe, cap_code}, {23'h0, 1'b0, 8'hE8});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule